// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides which clock domains of a small controller-class system run while the processor sleeps. Software programs a sleep-enable bit, a 3-bit mode code and an oscillator start-up count through a simple write port; a one-cycle sleep request then puts the system into the selected low-power state. In each state the block drives separate clock enables for the CPU, flash, general I/O, ADC and asynchronous-timer domains, plus an enable for the main oscillator.

While asleep it watches four wake sources. These are an external interrupt or reset request, an event from an I/O-clocked peripheral, an ADC completion and an asynchronous-timer event. Each mode accepts only the sources whose clock domain is still running, and the external source is accepted in every mode. On a qualified wake the block restores the clocks. If the mode had stopped the oscillator, it first re-enables the oscillator and waits a programmed number of reference ticks before giving any domain its clock back.

Top module: `sleep_ctrl`

## Requirements
- R1: While `rst_ni` is low and just after it rises, every clock enable and `osc_en_o` are 1, `state_o` is 0 (awake) and `mode_o` is 000.
- R2: Mode 000 (idle) gates only the CPU and flash clocks. Read as {osc, async, adc, io, flash, cpu}, the enables are 111100 while asleep.
- R3: Mode 001 (ADC noise reduction) gives enables 111000: only the oscillator, the asynchronous-timer domain and the ADC domain stay on.
- R4: Mode 010 (power-down) turns off the oscillator and every domain, giving enables 000000.
- R5: Mode 011 (power-save) gives enables 010000: only the asynchronous-timer domain keeps its clock.
- R6: Mode 110 (standby) gives enables 100000: the oscillator runs and every domain is gated.
- R7: Mode 111 (extended standby) gives enables 110000: the oscillator and the asynchronous-timer domain run.
- R8: With mode 100 or 101 selected, a sleep request leaves the block awake and all enables at 1.
- R9: A sleep request enters sleep only if the sleep-enable bit is 1 at that edge. Otherwise the block stays awake.
- R10: If a wake source that the selected mode accepts is high in the same cycle as the request, sleep is not entered. A source that the mode does not accept does not block entry.
- R11: The external wake is accepted in every mode. The I/O wake is accepted only in idle. The ADC wake is accepted only in idle and ADC noise reduction. The asynchronous-timer wake is accepted only in idle, ADC noise reduction, power-save and extended standby. A wake that the mode does not accept leaves the block asleep with its enables unchanged.
- R12: A wake from power-down or power-save moves to start-up (`state_o` = 2). In start-up only `osc_en_o` is 1. The block stays there until `tick_i` has been high on the programmed number of cycles. On the cycle after the count is exhausted it returns to awake. Cycles without a tick do not count, and a count of 0 gives exactly one start-up cycle.
- R13: A wake from a mode whose oscillator runs returns to awake with all enables at 1 on the next cycle.
- R14: `state_o` reports 0 for awake, 1 for asleep and 2 for start-up. `mode_o` holds the code of the mode most recently entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the configuration fields |
| cfg_sleep_en_i | input | 1 | Sleep-enable bit to write |
| cfg_mode_i | input | 3 | Sleep mode code to write |
| cfg_startup_i | input | CNT_W | Oscillator start-up count, in ticks |
| sleep_req_i | input | 1 | One-cycle request to enter the selected mode |
| tick_i | input | 1 | Reference tick for the start-up count |
| wake_ext_i | input | 1 | External interrupt or reset request wake |
| wake_io_i | input | 1 | Wake from an I/O-clocked peripheral |
| wake_adc_i | input | 1 | ADC conversion complete wake |
| wake_async_i | input | 1 | Asynchronous-timer wake |
| clk_cpu_en_o | output | 1 | CPU clock enable |
| clk_flash_en_o | output | 1 | Flash clock enable |
| clk_io_en_o | output | 1 | General I/O clock enable |
| clk_adc_en_o | output | 1 | ADC clock enable |
| clk_async_en_o | output | 1 | Asynchronous-timer clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| state_o | output | 2 | 0 awake, 1 asleep, 2 start-up |
| mode_o | output | 3 | Mode code of the current or last sleep |

## Verification
The hardest situation to reach is a wake event that is already asserted when the sleep request arrives. That event must cancel entry only if the selected mode accepts it. The bench sets up this case directly: it holds a wake line high across the request edge, once with an accepted source and once with a rejected one, and then checks whether the block left the awake state. A second case is also hard to reach, because start-up must count ticks rather than cycles. The bench spaces the ticks with idle cycles between them and checks that the block stays in start-up until the last programmed tick.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  localparam int NDOM  = 5;
  localparam int DOM_CPU = 0, DOM_FLASH = 1, DOM_IO = 2, DOM_ADC = 3, DOM_ASYNC = 4;
  localparam int NWAKE = 4;
  localparam int WK_EXT = 0, WK_IO = 1, WK_ADC = 2, WK_ASYNC = 3;

  localparam logic [2:0] M_IDLE  = 3'b000;
  localparam logic [2:0] M_ADCNR = 3'b001;
  localparam logic [2:0] M_PDOWN = 3'b010;
  localparam logic [2:0] M_PSAVE = 3'b011;
  localparam logic [2:0] M_STBY  = 3'b110;
  localparam logic [2:0] M_XSTBY = 3'b111;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_SLEEP = 2'd1,
    ST_START = 2'd2
  } state_e;

  typedef struct packed {
    logic             valid;
    logic             osc_run;
    logic [NDOM-1:0]  dom_run;
    logic [NWAKE-1:0] wake_ok;
  } mode_cfg_t;
endpackage

// File: rtl/sleep_mode_decode.sv
module sleep_mode_decode
  import sleep_pkg::*;
(
  input  logic [2:0] mode_i,
  output mode_cfg_t  cfg_o
);
  logic [NDOM-1:0] run;
  logic            osc;
  logic            ok;

  always_comb begin
    ok  = 1'b1;
    osc = 1'b1;
    run = '0;
    unique case (mode_i)
      M_IDLE:  begin run[DOM_IO] = 1'b1; run[DOM_ADC] = 1'b1; run[DOM_ASYNC] = 1'b1; end
      M_ADCNR: begin run[DOM_ADC] = 1'b1; run[DOM_ASYNC] = 1'b1; end
      M_PDOWN: osc = 1'b0;
      M_PSAVE: begin osc = 1'b0; run[DOM_ASYNC] = 1'b1; end
      M_STBY:  ;
      M_XSTBY: run[DOM_ASYNC] = 1'b1;
      default: ok = 1'b0;
    endcase
  end

  // a wake source counts only where its domain is clocked
  always_comb begin
    cfg_o.valid             = ok;
    cfg_o.osc_run           = osc;
    cfg_o.dom_run           = run;
    cfg_o.wake_ok[WK_EXT]   = 1'b1;
    cfg_o.wake_ok[WK_IO]    = run[DOM_IO];
    cfg_o.wake_ok[WK_ADC]   = run[DOM_ADC];
    cfg_o.wake_ok[WK_ASYNC] = run[DOM_ASYNC];
  end
endmodule

// File: rtl/sleep_wake_qual.sv
module sleep_wake_qual
  import sleep_pkg::*;
(
  input  logic [NWAKE-1:0] wake_i,
  input  logic [NWAKE-1:0] mask_i,
  output logic             hit_o
);
  logic [NWAKE-1:0] q;
  for (genvar g = 0; g < NWAKE; g++) begin : g_q
    assign q[g] = wake_i[g] & mask_i[g];
  end
  assign hit_o = |q;
endmodule

// File: rtl/sleep_startup_cnt.sv
module sleep_startup_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (load_i)                         cnt_q <= load_val_i;
    else if (run_i && tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_sleep_en_i,
  input  logic [2:0]       cfg_mode_i,
  input  logic [CNT_W-1:0] cfg_startup_i,
  input  logic             sleep_req_i,
  input  logic             tick_i,
  input  logic             wake_ext_i,
  input  logic             wake_io_i,
  input  logic             wake_adc_i,
  input  logic             wake_async_i,
  output logic             clk_cpu_en_o,
  output logic             clk_flash_en_o,
  output logic             clk_io_en_o,
  output logic             clk_adc_en_o,
  output logic             clk_async_en_o,
  output logic             osc_en_o,
  output logic [1:0]       state_o,
  output logic [2:0]       mode_o
);
  logic             cfg_en_q;
  logic [2:0]       cfg_mode_q;
  logic [CNT_W-1:0] cfg_start_q;
  state_e           state_q, state_d;
  logic [2:0]       act_mode_q;

  logic [2:0]       sel_mode;
  mode_cfg_t        dec;
  logic [NWAKE-1:0] wake_vec;
  logic             hit;
  logic             cnt_load, cnt_done;
  logic [NDOM-1:0]  dom_en;
  logic             osc_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_en_q    <= 1'b0;
      cfg_mode_q  <= M_IDLE;
      cfg_start_q <= '0;
    end else if (cfg_we_i) begin
      cfg_en_q    <= cfg_sleep_en_i;
      cfg_mode_q  <= cfg_mode_i;
      cfg_start_q <= cfg_startup_i;
    end
  end

  // awake: judge the requested mode; otherwise the one in force
  assign sel_mode = (state_q == ST_AWAKE) ? cfg_mode_q : act_mode_q;

  sleep_mode_decode i_dec (
    .mode_i (sel_mode),
    .cfg_o  (dec)
  );

  assign wake_vec = {wake_async_i, wake_adc_i, wake_io_i, wake_ext_i};

  sleep_wake_qual i_qual (
    .wake_i (wake_vec),
    .mask_i (dec.wake_ok),
    .hit_o  (hit)
  );

  assign cnt_load = (state_q == ST_SLEEP) && hit && !dec.osc_run;

  sleep_startup_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cfg_start_q),
    .run_i      (state_q == ST_START),
    .tick_i     (tick_i),
    .done_o     (cnt_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE: if (sleep_req_i && cfg_en_q && dec.valid && !hit) state_d = ST_SLEEP;
      ST_SLEEP: if (hit) state_d = dec.osc_run ? ST_AWAKE : ST_START;
      ST_START: if (cnt_done) state_d = ST_AWAKE;
      default:  state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_AWAKE;
      act_mode_q <= M_IDLE;
    end else begin
      state_q <= state_d;
      if (state_q == ST_AWAKE && state_d == ST_SLEEP) act_mode_q <= cfg_mode_q;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_SLEEP: begin dom_en = dec.dom_run; osc_en = dec.osc_run; end
      ST_START: begin dom_en = '0;          osc_en = 1'b1;        end
      default:  begin dom_en = '1;          osc_en = 1'b1;        end
    endcase
  end

  assign clk_cpu_en_o   = dom_en[DOM_CPU];
  assign clk_flash_en_o = dom_en[DOM_FLASH];
  assign clk_io_en_o    = dom_en[DOM_IO];
  assign clk_adc_en_o   = dom_en[DOM_ADC];
  assign clk_async_en_o = dom_en[DOM_ASYNC];
  assign osc_en_o       = osc_en;
  assign state_o        = state_q;
  assign mode_o         = act_mode_q;
endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_req_i,
  input logic       wake_ext_i,
  input logic       clk_cpu_en_o,
  input logic       clk_flash_en_o,
  input logic       osc_en_o,
  input logic [1:0] state_o,
  input logic [2:0] mode_o,
  input logic [2:0] cfg_mode_q
);
  p_cpu_only_awake_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_cpu_en_o || clk_flash_en_o) |-> state_o == 2'd0);

  p_osc_off_slow_modes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (state_o == 2'd1 && (mode_o == 3'b010 || mode_o == 3'b011)));

  p_reserved_stays_awake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && cfg_mode_q[2:1] == 2'b10) |=> state_o == 2'd0);

  p_no_req_no_sleep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && !sleep_req_i) |=> state_o == 2'd0);

  p_pdown_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && mode_o == 3'b010 && !wake_ext_i) |=> state_o == 2'd1);

  p_slow_wake_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && !osc_en_o && wake_ext_i) |=> state_o == 2'd2);

  p_startup_gated_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd2 |-> (osc_en_o && !clk_cpu_en_o));

  p_fast_wake_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && osc_en_o && wake_ext_i) |=> state_o == 2'd0);

  p_state_code_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3);
endmodule

bind sleep_ctrl sleep_ctrl_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sleep_req_i    (sleep_req_i),
  .wake_ext_i     (wake_ext_i),
  .clk_cpu_en_o   (clk_cpu_en_o),
  .clk_flash_en_o (clk_flash_en_o),
  .osc_en_o       (osc_en_o),
  .state_o        (state_o),
  .mode_o         (mode_o),
  .cfg_mode_q     (cfg_mode_q)
);

// File: tb/test_sleep_ctrl.sv
module test_sleep_ctrl;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we = 0, cfg_sleep_en = 0;
  logic [2:0] cfg_mode = 0;
  logic [CNT_W-1:0] cfg_startup = 0;
  logic sleep_req = 0, tick = 0;
  logic wake_ext = 0, wake_io = 0, wake_adc = 0, wake_async = 0;
  logic cpu_en, flash_en, io_en, adc_en, async_en, osc_en;
  logic [1:0] state;
  logic [2:0] mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sleep_ctrl #(.CNT_W(CNT_W)) i_sleep_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sleep_en_i(cfg_sleep_en),
    .cfg_mode_i(cfg_mode), .cfg_startup_i(cfg_startup), .sleep_req_i(sleep_req),
    .tick_i(tick), .wake_ext_i(wake_ext), .wake_io_i(wake_io), .wake_adc_i(wake_adc),
    .wake_async_i(wake_async), .clk_cpu_en_o(cpu_en), .clk_flash_en_o(flash_en),
    .clk_io_en_o(io_en), .clk_adc_en_o(adc_en), .clk_async_en_o(async_en),
    .osc_en_o(osc_en), .state_o(state), .mode_o(mode)
  );

  // {mode, expected {osc,async,adc,io,flash,cpu}}
  localparam logic [8:0] VEC [6] = '{
    {3'b000, 6'b111100},
    {3'b001, 6'b111000},
    {3'b010, 6'b000000},
    {3'b011, 6'b010000},
    {3'b110, 6'b100000},
    {3'b111, 6'b110000}
  };
  localparam string VREQ [6] = '{"R2", "R3", "R4", "R5", "R6", "R7"};

  function automatic logic [7:0] obs();
    return {state, osc_en, async_en, adc_en, io_en, flash_en, cpu_en};
  endfunction

  task automatic chk(string req, logic [7:0] exp);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, obs(), exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(logic en, logic [2:0] m, logic [CNT_W-1:0] s);
    cfg_we = 1; cfg_sleep_en = en; cfg_mode = m; cfg_startup = s;
    step();
    cfg_we = 0;
  endtask

  task automatic req();
    sleep_req = 1;
    step();
    sleep_req = 0;
  endtask

  task automatic pulse_tick();
    tick = 1;
    step();
    tick = 0;
  endtask

  localparam logic [7:0] AWAKE = {2'd0, 6'b111111};
  localparam logic [7:0] START = {2'd2, 6'b100000};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2;
    chk("R1 in reset", AWAKE);
    step(); step();
    rst_ni = 1;
    step();
    chk("R1 after reset", AWAKE);
    checks++;
    if (mode !== 3'b000) begin errors++; $display("FAIL R1 mode: actual %b expected 000", mode); end

    // table walk: enter each mode, wake by external source
    for (int i = 0; i < 6; i++) begin
      logic [2:0] m;
      logic [5:0] e;
      m = VEC[i][8:6];
      e = VEC[i][5:0];
      cfg(1, m, 2);
      req();
      chk(VREQ[i], {2'd1, e});
      checks++;
      if (mode !== m) begin errors++; $display("FAIL R14 mode: actual %b expected %b", mode, m); end
      wake_ext = 1;
      step();
      wake_ext = 0;
      if (e[5]) begin
        chk("R13 fast wake", AWAKE);
      end else begin
        chk("R12 enter startup", START);
        step();
        chk("R12 no tick no count", START);
        pulse_tick();
        step();
        pulse_tick();
        chk("R12 last tick", START);
        step();
        chk("R12 release", AWAKE);
      end
    end

    // reserved codes
    cfg(1, 3'b100, 0); req(); chk("R8 code 100", AWAKE);
    cfg(1, 3'b101, 0); req(); chk("R8 code 101", AWAKE);

    // sleep enable off
    cfg(0, 3'b000, 0); req(); chk("R9 enable off", AWAKE);

    // pending accepted wake aborts entry
    cfg(1, 3'b010, 0);
    wake_ext = 1; req(); wake_ext = 0;
    chk("R10 pending ext aborts", AWAKE);
    // pending rejected wake does not abort
    wake_adc = 1; req(); wake_adc = 0;
    chk("R10 rejected pending enters", {2'd1, 6'b000000});

    // power-down ignores io, adc, async
    wake_async = 1; step(); wake_async = 0; chk("R11 pdown ignores async", {2'd1, 6'b000000});
    wake_adc = 1;   step(); wake_adc = 0;   chk("R11 pdown ignores adc", {2'd1, 6'b000000});
    wake_io = 1;    step(); wake_io = 0;    chk("R11 pdown ignores io", {2'd1, 6'b000000});
    wake_ext = 1;   step(); wake_ext = 0;   chk("R12 zero count startup", START);
    step(); chk("R12 zero count release", AWAKE);

    // power-save woken by async timer
    cfg(1, 3'b011, 1); req();
    wake_async = 1; step(); wake_async = 0; chk("R11 psave async wakes", START);
    pulse_tick(); step(); chk("R12 one tick release", AWAKE);

    // ADC noise reduction woken by ADC, not by io
    cfg(1, 3'b001, 0); req();
    wake_io = 1; step(); wake_io = 0; chk("R11 adcnr ignores io", {2'd1, 6'b111000});
    wake_adc = 1; step(); wake_adc = 0; chk("R11 adcnr adc wakes", AWAKE);

    // standby ignores async; idle woken by io
    cfg(1, 3'b110, 0); req();
    wake_async = 1; step(); wake_async = 0; chk("R11 standby ignores async", {2'd1, 6'b100000});
    wake_ext = 1; step(); wake_ext = 0; chk("R13 standby wake", AWAKE);
    cfg(1, 3'b000, 0); req();
    wake_io = 1; step(); wake_io = 0; chk("R11 idle io wakes", AWAKE);

    // reset during power-down
    cfg(1, 3'b010, 0); req();
    chk("R4 before reset", {2'd1, 6'b000000});
    rst_ni = 0; #1;
    chk("R1 reset while asleep", AWAKE);
    step(); rst_ni = 1; step();
    chk("R1 after sleep reset", AWAKE);
    checks++;
    if (mode !== 3'b000) begin errors++; $display("FAIL R14 mode after reset: actual %b expected 000", mode); end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule